// File: doc/BRIEF.md
# Base Address Window Validator

This block turns the contents of six base address registers and one expansion ROM register into decode windows. For every region it works out an aligned base and an inclusive last address from the register value and the region's power-of-two size. It then decides whether that window may decode at all. The decision uses the region's type (I/O or memory), the command enables for I/O and memory space, the ROM decode bit and a set of rules that reject degenerate or out-of-range windows.

The windows are captured only when a remap strobe is pulsed, so the configuration inputs may move freely in between. A per-region change pulse marks every window whose decode state moved in that capture. An address match port takes an I/O or memory request strobe with an address and reports the lowest-numbered valid region of the matching type whose window covers it.

Top module: `addr_window_validator`

## Requirements
- R1: For a valid region, `win_base` equals the register value with its low log2(size) bits cleared, and `win_last` equals `win_base` + size − 1. A region that is not valid reports zero on both.
- R2: A region whose size is zero, or whose size is not a power of two, is never valid.
- R3: An I/O region is valid only when `cmd_io_en` is 1. A memory region and the ROM region are valid only when `cmd_mem_en` is 1.
- R4: The ROM region is index 6 (the highest) and is always memory type. It is valid only when bit 0 of its register value is 1.
- R5: A region whose base is zero, or whose last address is not above its base (size 1), is not valid.
- R6: An I/O region whose last address is 0x10000 or above is not valid.
- R7: A memory or ROM region whose last address is all ones is not valid.
- R8: `win_valid`, `win_base` and `win_last` take their new values at the clock edge that samples `remap` high, and hold while `remap` is low.
- R9: `win_changed[i]` is 1 for the single cycle after a remap in which region i's valid state, base or last address changed, and is 0 otherwise.
- R10: With `io_req` high, only valid I/O windows match. With `mem_req` high, only valid memory and ROM windows match. Bounds are inclusive, the lowest index wins, and with no match or no request `hit` is 0 and `hit_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| remap | input | 1 | Capture strobe: recompute all windows |
| cmd_io_en | input | 1 | Command I/O space enable |
| cmd_mem_en | input | 1 | Command memory space enable |
| reg_val | input | 7x32 | Register value per region, index 6 is the ROM |
| reg_size | input | 7x32 | Region size in bytes per region |
| reg_is_io | input | 6 | Type of regions 0..5: 1 = I/O, 0 = memory |
| io_req | input | 1 | I/O address match request |
| mem_req | input | 1 | Memory address match request |
| req_addr | input | 32 | Address to match |
| win_valid | output | 7 | Window decodes |
| win_base | output | 7x32 | Window base address |
| win_last | output | 7x32 | Window last address |
| win_changed | output | 7 | One-cycle pulse: window moved in the last remap |
| hit | output | 1 | Some valid window of the requested type covers the address |
| hit_idx | output | 3 | Lowest matching region index |

## Verification
Every cycle, the assertions check the invariants of captured windows: a nonzero base below the last address, I/O windows under 64 KiB, and memory windows not reaching the top address. They also check the ROM decode bit, that outputs hold without a remap, that change pulses only follow a remap, and that a hit always carries a request and a valid region. Only the bench's scenarios can show the actual base and last values, the enable and size rejections, which regions pulse `win_changed`, and lowest-index priority between overlapping windows. The bench drives these through a sequence of register, enable and size configurations, with addresses placed at window edges.

// File: rtl/awv_pkg.sv
package awv_pkg;
  typedef enum logic [1:0] {
    RK_MEM = 2'd0,
    RK_IO  = 2'd1,
    RK_ROM = 2'd2
  } region_kind_e;
endpackage

// File: rtl/awv_region_eval.sv
module awv_region_eval
  import awv_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int IO_SPACE_BITS = 16
) (
  input  logic [ADDR_W-1:0] cfg_val,
  input  logic [ADDR_W-1:0] cfg_size,
  input  region_kind_e      kind,
  input  logic              io_en,
  input  logic              mem_en,
  output logic              ok,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] last
);
  function automatic logic f_pow2(logic [ADDR_W-1:0] s);
    return (s != '0) && ((s & (s - 1'b1)) == '0);
  endfunction

  function automatic logic [ADDR_W-1:0] f_base(logic [ADDR_W-1:0] v, logic [ADDR_W-1:0] s);
    return v & ~(s - 1'b1);
  endfunction

  function automatic logic [ADDR_W-1:0] f_last(logic [ADDR_W-1:0] b, logic [ADDR_W-1:0] s);
    return b + (s - 1'b1);
  endfunction

  logic size_ok, enabled, span_ok, type_ok;

  always_comb begin
    base    = f_base(cfg_val, cfg_size);
    last    = f_last(base, cfg_size);
    size_ok = f_pow2(cfg_size);
    unique case (kind)
      RK_IO:   enabled = io_en;
      RK_ROM:  enabled = mem_en && cfg_val[0];
      default: enabled = mem_en;
    endcase
    span_ok = (last > base) && (base != '0);
    if (kind == RK_IO) type_ok = ((last >> IO_SPACE_BITS) == '0);
    else               type_ok = (last != '1);
    ok = size_ok && enabled && span_ok && type_ok;
  end
endmodule

// File: rtl/awv_hit_select.sv
module awv_hit_select #(
  parameter int NUM    = 7,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM-1:0]             valid,
  input  logic [NUM-1:0]             is_io,
  input  logic [NUM-1:0][ADDR_W-1:0] base,
  input  logic [NUM-1:0][ADDR_W-1:0] last,
  input  logic                       io_req,
  input  logic                       mem_req,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_idx
);
  logic [NUM-1:0] match;

  for (genvar g = 0; g < NUM; g++) begin : g_match
    assign match[g] = valid[g]
                    && ((is_io[g] && io_req) || (!is_io[g] && mem_req))
                    && (addr >= base[g]) && (addr <= last[g]);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // R10
  hit_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (io_req || mem_req));
  // R10
  hit_region_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> valid[hit_idx]);
endmodule

// File: rtl/addr_window_validator.sv
module addr_window_validator
  import awv_pkg::*;
#(
  parameter int NUM_BARS      = 6,
  parameter int ADDR_W        = 32,
  parameter int IO_SPACE_BITS = 16,
  localparam int NUM_REGIONS  = NUM_BARS + 1,
  localparam int ROM_IDX      = NUM_REGIONS - 1,
  localparam int IDX_W        = $clog2(NUM_REGIONS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               remap,
  input  logic                               cmd_io_en,
  input  logic                               cmd_mem_en,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] reg_val,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] reg_size,
  input  logic [NUM_BARS-1:0]                reg_is_io,
  input  logic                               io_req,
  input  logic                               mem_req,
  input  logic [ADDR_W-1:0]                  req_addr,
  output logic [NUM_REGIONS-1:0]             win_valid,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0] win_base,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0] win_last,
  output logic [NUM_REGIONS-1:0]             win_changed,
  output logic                               hit,
  output logic [IDX_W-1:0]                   hit_idx
);
  // evaluated (next) window per region, brought out for the assertions
  logic [NUM_REGIONS-1:0]             nxt_ok;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] nxt_base, nxt_last;
  logic [NUM_REGIONS-1:0]             nxt_io;
  logic [NUM_REGIONS-1:0]             win_io_q;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    region_kind_e kind;
    if (g == ROM_IDX) begin : g_rom
      assign kind = RK_ROM;
    end else begin : g_bar
      assign kind = reg_is_io[g] ? RK_IO : RK_MEM;
    end
    assign nxt_io[g] = (kind == RK_IO);

    awv_region_eval #(.ADDR_W(ADDR_W), .IO_SPACE_BITS(IO_SPACE_BITS)) u_eval (
      .cfg_val (reg_val[g]),
      .cfg_size(reg_size[g]),
      .kind    (kind),
      .io_en   (cmd_io_en),
      .mem_en  (cmd_mem_en),
      .ok      (nxt_ok[g]),
      .base    (nxt_base[g]),
      .last    (nxt_last[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid   <= '0;
      win_base    <= '0;
      win_last    <= '0;
      win_io_q    <= '0;
      win_changed <= '0;
    end else begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        win_changed[i] <= 1'b0;
        if (remap) begin
          win_valid[i]   <= nxt_ok[i];
          win_base[i]    <= nxt_ok[i] ? nxt_base[i] : '0;
          win_last[i]    <= nxt_ok[i] ? nxt_last[i] : '0;
          win_io_q[i]    <= nxt_io[i];
          win_changed[i] <= (nxt_ok[i] != win_valid[i])
                         || (nxt_ok[i] && ((nxt_base[i] != win_base[i])
                                        || (nxt_last[i] != win_last[i])));
        end
      end
    end
  end

  awv_hit_select #(.NUM(NUM_REGIONS), .ADDR_W(ADDR_W)) u_hit (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (win_valid),
    .is_io  (win_io_q),
    .base   (win_base),
    .last   (win_last),
    .io_req (io_req),
    .mem_req(mem_req),
    .addr   (req_addr),
    .hit    (hit),
    .hit_idx(hit_idx)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_chk
    // R5
    win_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid[g] |-> (win_base[g] != '0) && (win_last[g] > win_base[g]));
    // R6
    io_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid[g] && win_io_q[g]) |-> ((win_last[g] >> IO_SPACE_BITS) == '0));
    // R7
    mem_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid[g] && !win_io_q[g]) |-> (win_last[g] != '1));
  end

  // R4
  rom_enable_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(win_valid[ROM_IDX]) && $past(remap)) |-> $past(reg_val[ROM_IDX][0]));
  // R8
  hold_without_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !remap |=> ($stable(win_valid) && $stable(win_base) && $stable(win_last)));
  // R9
  changed_after_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_changed != '0) |-> $past(remap));
endmodule

// File: tb/addr_window_validator_tb.sv
`timescale 1ns/1ps
module addr_window_validator_tb;
  localparam int N = 7;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic remap = 1'b0;
  logic io_en = 1'b0, mem_en = 1'b0;
  logic [N-1:0][W-1:0] cfg_val = '0, cfg_size = '0;
  logic [N-2:0] cfg_io = '0;
  logic io_req = 1'b0, mem_req = 1'b0;
  logic [W-1:0] addr = '0;
  logic [N-1:0] win_valid, win_changed;
  logic [N-1:0][W-1:0] win_base, win_last;
  logic hit;
  logic [2:0] hit_idx;

  always #4 clk = ~clk;

  addr_window_validator u_dut (
    .clk(clk), .rst_n(rst_n), .remap(remap), .cmd_io_en(io_en), .cmd_mem_en(mem_en),
    .reg_val(cfg_val), .reg_size(cfg_size), .reg_is_io(cfg_io),
    .io_req(io_req), .mem_req(mem_req), .req_addr(addr),
    .win_valid(win_valid), .win_base(win_base), .win_last(win_last),
    .win_changed(win_changed), .hit(hit), .hit_idx(hit_idx));

  typedef struct {
    logic [N-1:0] v;
    logic [N-1:0] ch;
    logic [W-1:0] b [N];
    logic [W-1:0] l [N];
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic bit mdl_window(int r, output logic [W-1:0] b, output logic [W-1:0] l);
    longint unsigned sz = cfg_size[r];
    longint unsigned v  = cfg_val[r];
    longint unsigned bb, ll;
    bit is_io = (r < N - 1) && cfg_io[r];
    bit en;
    b = '0; l = '0;
    if (sz == 0 || $countones(cfg_size[r]) != 1) return 0;      // R2
    en = is_io ? io_en : mem_en;                                 // R3
    if (r == N - 1 && !cfg_val[r][0]) en = 0;                    // R4
    if (!en) return 0;
    bb = (v / sz) * sz;
    ll = bb + sz - 1;
    if (bb == 0 || ll <= bb) return 0;                           // R5
    if (is_io && ll >= 64'h10000) return 0;                      // R6
    if (!is_io && ll == 64'hFFFF_FFFF) return 0;                 // R7
    b = bb[W-1:0]; l = ll[W-1:0];
    return 1;
  endfunction

  task automatic check(bit cond, string req, string what, longint unsigned act, longint unsigned expv);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // driver: sets a configuration, pulses remap, pushes the expected windows
  task automatic apply(string tag);
    exp_t e;
    @(negedge clk);
    for (int r = 0; r < N; r++) begin
      logic [W-1:0] b, l;
      e.v[r] = mdl_window(r, b, l);
      e.b[r] = b; e.l[r] = l;
      e.ch[r] = (e.v[r] != cur.v[r]) || (e.v[r] && (b != cur.b[r] || l != cur.l[r]));
    end
    e.tag = tag;
    cur = e;
    exp_q.push_back(e);
    remap = 1'b1;
    @(negedge clk);
    remap = 1'b0;
    @(negedge clk);
  endtask

  // monitor: after each captured remap, pop and compare
  initial begin
    forever begin
      @(posedge clk);
      if (remap && rst_n) begin
        exp_t e;
        @(negedge clk);
        e = exp_q.pop_front();
        for (int r = 0; r < N; r++) begin
          check(win_valid[r] == e.v[r], e.tag, $sformatf("valid[%0d]", r), win_valid[r], e.v[r]);
          check(win_base[r] == e.b[r] && win_last[r] == e.l[r], "R1",
                $sformatf("%s base/last[%0d]", e.tag, r),
                {win_base[r], win_last[r]}, {e.b[r], e.l[r]});
          check(win_changed[r] == e.ch[r], "R9", $sformatf("changed[%0d]", r),
                win_changed[r], e.ch[r]);
        end
        @(negedge clk);
        check(win_changed == '0, "R9", "changed pulse length", win_changed, 0);
      end
    end
  end

  task automatic probe(bit io, bit mem, logic [W-1:0] a, string req);
    bit eh = 0;
    int ei = 0;
    @(negedge clk);
    io_req = io; mem_req = mem; addr = a;
    for (int r = N - 1; r >= 0; r--) begin
      bit rio = (r < N - 1) && cfg_io[r];
      if (cur.v[r] && ((rio && io) || (!rio && mem)) && a >= cur.b[r] && a <= cur.l[r]) begin
        eh = 1; ei = r;
      end
    end
    #2;
    check(hit == eh && hit_idx == ei[2:0], req, $sformatf("hit@%0h", a), {hit, hit_idx}, {eh, ei[2:0]});
    io_req = 0; mem_req = 0;
  endtask

  initial begin
    cur.v = '0; cur.ch = '0;
    for (int r = 0; r < N; r++) begin cur.b[r] = '0; cur.l[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(win_valid == '0 && win_changed == '0, "R8", "reset state", {win_valid, win_changed}, 0);
    probe(1, 1, 32'h1000, "R10");

    io_en = 1; mem_en = 1;
    cfg_io = 6'b01_1001;
    cfg_val[0] = 32'h0000_1003; cfg_size[0] = 32'h10;
    cfg_val[1] = 32'h8000_0123; cfg_size[1] = 32'h1000;
    cfg_val[2] = 32'h4000_0000; cfg_size[2] = 32'h0;
    cfg_val[3] = 32'h0000_000C; cfg_size[3] = 32'h10;
    cfg_val[4] = 32'h0000_FFF0; cfg_size[4] = 32'h20;
    cfg_val[5] = 32'hFFFF_F000; cfg_size[5] = 32'h1000;
    cfg_val[6] = 32'h8000_0000; cfg_size[6] = 32'h1_0000;
    apply("R2 R5 R7 mixed");
    probe(1, 0, 32'h0000_1005, "R10");
    probe(0, 1, 32'h0000_1005, "R10");
    probe(1, 0, 32'h0000_FFFF, "R10");

    cfg_val[6] = 32'h8000_0001;
    apply("R4 rom enable");
    probe(0, 1, 32'h8000_0010, "R10");
    probe(0, 1, 32'h8000_8000, "R10");
    probe(0, 1, 32'h8001_0000, "R10");
    probe(0, 0, 32'h8000_0010, "R10");

    cfg_val[4] = 32'h0001_0000; cfg_size[4] = 32'h1_0000;
    cfg_size[2] = 32'h3000;
    cfg_val[3] = 32'h0000_2000; cfg_size[3] = 32'h1;
    apply("R6 R2 R5 io limit");

    cfg_val[4] = 32'h0000_FF44; cfg_size[4] = 32'h100;
    cfg_size[2] = 32'h2000_0000; cfg_val[2] = 32'hEFFF_FFFF;
    apply("R6 R7 edges");

    io_en = 0;
    apply("R3 io off");
    io_en = 1; mem_en = 0;
    apply("R3 mem off");
    mem_en = 1;
    apply("R3 both on");
    apply("R9 no change");

    cfg_val[0] = 32'h0000_3000; io_en = 0;
    repeat (4) @(negedge clk);
    for (int r = 0; r < N; r++)
      check(win_valid[r] == cur.v[r] && win_base[r] == cur.b[r], "R8",
            $sformatf("hold[%0d]", r), {win_valid[r], win_base[r]}, {cur.v[r], cur.b[r]});
    probe(1, 0, 32'h0000_1008, "R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule